// File: doc/BRIEF.md
# Page write load controller

This block is the write-side control of a byte-wide nonvolatile memory. The host drives active-low chip-select, write and output-enable strobes together with the address and data buses. The block runs on its own clock and samples those strobes on every rising edge. Each qualified write strobe loads one byte into a page buffer.

The first byte that is accepted fixes which page is open. More bytes for that page may follow for as long as each new strobe arrives before a byte-load timeout runs out. When the host stops loading, the block raises `busy` and runs a self-timed programming interval. At the end of that interval, every buffered position is committed to the storage array at once. No erase step comes first, and positions that were not loaded keep their old contents.

The same strobes also read the array, through a registered read port. The byte-load timeout and the programming interval are parameters counted in clock cycles.

Top module: `pgwr_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy` is 0, `rd_data` is 0, no page is open, and every array byte reads back as 0.
- R2: A write strobe exists in each sampled cycle where `cs_n`=0, `we_n`=0 and `oe_n`=1. The address is taken from the first sampled cycle of the strobe, whichever of `cs_n` or `we_n` fell last. The data is taken from the last sampled cycle before `cs_n` or `we_n` returns high.
- R3: A strobe that ends because `oe_n` went low loads nothing. With `cs_n` high, `we_n` high or `oe_n` low, no write takes place and programming never starts.
- R4: `addr[5:0]` selects the byte within a page and the upper address bits select the page. While a page is open, a strobe that carries a different page is ignored and does not extend the load window.
- R5: Suppose the release of the last accepted strobe is sampled at edge F. Then `busy` rises at edge F+LOAD_TMO. A strobe whose first active sample is at or before that edge joins the page. A strobe sampled after that edge is ignored.
- R6: `busy` stays high for exactly PROG_CYC cycles. The loaded bytes appear in the array at the same edge where `busy` falls.
- R7: Write strobes that start while `busy` is high load nothing.
- R8: Page positions that were not loaded keep their previous contents. When one position is loaded twice, the later byte is the one that is stored.
- R9: In each cycle sampled with `cs_n`=0, `oe_n`=0 and `we_n`=1, `rd_data` takes the array byte at `addr` on that edge. Otherwise `rd_data` holds. While `busy` is high, reads return the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address: page in the upper bits, offset in bits 5..0 |
| din | input | DATA_W | Write data |
| busy | output | 1 | High while the programming interval runs |
| rd_data | output | DATA_W | Registered read data |

## Verification
The release of a write strobe is sampled at some edge F. From that edge, `busy` is due high at F+LOAD_TMO and low again at F+LOAD_TMO+PROG_CYC, and the committed bytes become readable at that falling edge. A read strobe sampled at one edge shows its byte on `rd_data` from that edge on. The bench drives and samples only on falling clock edges. It counts rising edges from each release to place the `busy` checks on the exact cycles just before and just after each transition. This includes a joining strobe sampled exactly at the timeout edge and one sampled a cycle later.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic {
    ST_OPEN = 1'b0,
    ST_PROG = 1'b1
  } pgwr_state_t;
endpackage

// File: rtl/pgwr_strobe.sv
// Strobe qualification plus address/data capture.
module pgwr_strobe #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              act_start,
  output logic              act_stop,
  output logic              act_end_ok,
  output logic [ADDR_W-1:0] adr_q,
  output logic [DATA_W-1:0] dat_q
);
  logic              act;
  logic              act_q;
  logic [ADDR_W-1:0] adr_n;
  logic [DATA_W-1:0] dat_n;

  assign act        = ~cs_n & ~we_n & oe_n;
  assign act_start  = act & ~act_q;
  assign act_stop   = act_q & ~act;
  // a release counts only when cs_n or we_n ended the strobe, not oe_n
  assign act_end_ok = act_stop & oe_n;

  always_comb begin
    adr_n = adr_q;
    dat_n = dat_q;
    if (act_start) adr_n = addr;
    if (act)       dat_n = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      adr_q <= '0;
      dat_q <= '0;
    end else begin
      act_q <= act;
      adr_q <= adr_n;
      dat_q <= dat_n;
    end
  end
endmodule

// File: rtl/pgwr_pagebuf.sv
// Page buffer with per-byte valid bits, page lock and acceptance.
module pgwr_pagebuf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6,
  parameter int PAGE_W = 4,
  localparam int NBYTES = 1 << OFF_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          act_start,
  input  logic                          act_stop,
  input  logic                          act_end_ok,
  input  logic [PAGE_W-1:0]             start_page,
  input  logic [PAGE_W-1:0]             ld_page,
  input  logic [OFF_W-1:0]              ld_off,
  input  logic [DATA_W-1:0]             ld_dat,
  input  logic                          busy,
  input  logic                          commit,
  output logic                          hold,
  output logic                          ld_we,
  output logic                          page_open,
  output logic [PAGE_W-1:0]             open_page,
  output logic [NBYTES-1:0][DATA_W-1:0] buf_dat,
  output logic [NBYTES-1:0]             buf_vld
);
  logic              accept_now;
  logic              ok_q;
  logic              ok_n;
  logic [PAGE_W-1:0] pg_n;
  logic [NBYTES-1:0] vld_n;

  assign page_open  = |buf_vld;
  assign accept_now = act_start & ~busy & (~page_open | (start_page == open_page));
  assign hold       = accept_now | ok_q;
  assign ld_we      = act_end_ok & ok_q;

  always_comb begin
    ok_n  = ok_q;
    pg_n  = open_page;
    vld_n = buf_vld;
    if (accept_now)    ok_n = 1'b1;
    else if (act_stop) ok_n = 1'b0;
    if (ld_we && !page_open) pg_n = ld_page;
    if (commit)      vld_n = '0;
    else if (ld_we)  vld_n[ld_off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q      <= 1'b0;
      open_page <= '0;
      buf_vld   <= '0;
    end else begin
      ok_q      <= ok_n;
      open_page <= pg_n;
      buf_vld   <= vld_n;
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic sel;
    assign sel = ld_we && (ld_off == OFF_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   buf_dat[i] <= '0;
      else if (sel) buf_dat[i] <= ld_dat;
    end
  end
endmodule

// File: rtl/pgwr_seq.sv
// Byte-load timeout and programming interval sequencer.
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int LOAD_TMO = 4000,
  parameter int PROG_CYC = 100000,
  localparam int TMO_W = $clog2(LOAD_TMO + 1),
  localparam int PRG_W = $clog2(PROG_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic page_open,
  output logic busy,
  output logic commit
);
  pgwr_state_t st_q, st_n;
  logic [TMO_W-1:0] tmo_q, tmo_n;
  logic [PRG_W-1:0] prg_q, prg_n;

  always_comb begin
    st_n   = st_q;
    tmo_n  = tmo_q;
    prg_n  = prg_q;
    commit = 1'b0;
    unique case (st_q)
      ST_OPEN: begin
        if (hold) begin
          tmo_n = '0;
        end else if (page_open) begin
          if (tmo_q == TMO_W'(LOAD_TMO - 1)) begin
            st_n  = ST_PROG;
            tmo_n = '0;
            prg_n = '0;
          end else begin
            tmo_n = tmo_q + 1'b1;
          end
        end
      end
      ST_PROG: begin
        if (prg_q == PRG_W'(PROG_CYC - 1)) begin
          commit = 1'b1;
          st_n   = ST_OPEN;
          prg_n  = '0;
        end else begin
          prg_n = prg_q + 1'b1;
        end
      end
      default: st_n = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OPEN;
      tmo_q <= '0;
      prg_q <= '0;
    end else begin
      st_q  <= st_n;
      tmo_q <= tmo_n;
      prg_q <= prg_n;
    end
  end

  assign busy = (st_q == ST_PROG);
endmodule

// File: rtl/pgwr_array.sv
// Storage array: whole-page commit and registered read.
module pgwr_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6,
  localparam int PAGE_W = ADDR_W - OFF_W,
  localparam int NBYTES = 1 << OFF_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic [PAGE_W-1:0]             cm_page,
  input  logic [NBYTES-1:0][DATA_W-1:0] cm_dat,
  input  logic [NBYTES-1:0]             cm_vld,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_n;

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    localparam int OFS = e % NBYTES;
    localparam int PGI = e / NBYTES;
    logic wr;
    assign wr = commit && (cm_page == PAGE_W'(PGI)) && cm_vld[OFS];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[e] <= '0;
      else if (wr) mem_q[e] <= cm_dat[OFS];
    end
  end

  always_comb begin
    rd_n = rd_data;
    if (rd_en) rd_n = mem_q[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_n;
  end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 6,
  parameter int LOAD_TMO = 4000,
  parameter int PROG_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int NBYTES = 1 << OFF_W;

  logic                          act_start, act_stop, act_end_ok;
  logic [ADDR_W-1:0]             adr_q;
  logic [DATA_W-1:0]             dat_q;
  logic                          hold, ld_we, page_open, commit, rd_en;
  logic [PAGE_W-1:0]             open_page;
  logic [NBYTES-1:0][DATA_W-1:0] buf_dat;
  logic [NBYTES-1:0]             buf_vld;

  assign rd_en = ~cs_n & ~oe_n & we_n;

  pgwr_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .act_start(act_start), .act_stop(act_stop),
    .act_end_ok(act_end_ok), .adr_q(adr_q), .dat_q(dat_q)
  );

  pgwr_pagebuf #(.DATA_W(DATA_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_pagebuf (
    .clk(clk), .rst_n(rst_n), .act_start(act_start), .act_stop(act_stop),
    .act_end_ok(act_end_ok), .start_page(addr[ADDR_W-1:OFF_W]),
    .ld_page(adr_q[ADDR_W-1:OFF_W]), .ld_off(adr_q[OFF_W-1:0]), .ld_dat(dat_q),
    .busy(busy), .commit(commit), .hold(hold), .ld_we(ld_we),
    .page_open(page_open), .open_page(open_page), .buf_dat(buf_dat), .buf_vld(buf_vld)
  );

  pgwr_seq #(.LOAD_TMO(LOAD_TMO), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .hold(hold), .page_open(page_open),
    .busy(busy), .commit(commit)
  );

  pgwr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cm_page(open_page),
    .cm_dat(buf_dat), .cm_vld(buf_vld), .rd_en(rd_en), .rd_addr(addr),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
  parameter int PAGE_W   = 4,
  parameter int PROG_CYC = 100000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              commit,
  input logic              ld_we,
  input logic              page_open,
  input logic [PAGE_W-1:0] ld_page,
  input logic [PAGE_W-1:0] open_page
);
  int unsigned bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  a_r7_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> !busy);
  a_r6_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy);
  a_r6_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == PROG_CYC));
  a_r4_page_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && page_open) |-> (ld_page == open_page));
  a_r5_prog_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> page_open);
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(.PAGE_W(PAGE_W), .PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .commit(commit), .ld_we(ld_we),
  .page_open(page_open), .ld_page(adr_q[ADDR_W-1:OFF_W]), .open_page(open_page)
);

// File: tb/pgwr_ctrl_bench.sv
module pgwr_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int OW = 6;
  localparam int T  = 20;
  localparam int P  = 30;
  localparam int NB = 1 << OW;
  localparam int DEPTH = 1 << AW;
  localparam int NPG = DEPTH / NB;

  logic clk, rst_n, cs_n, we_n, oe_n, busy;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, rd_data;

  pgwr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(OW), .LOAD_TMO(T), .PROG_CYC(P)) u_pgwr_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .busy(busy), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] pend_dat [NB];
  bit            pend_vld [NB];
  bit            pend_open;
  int            pend_page;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_byte(input int a);
    return mdl[a];
  endfunction

  function automatic int page_of(input int a);
    return a / NB;
  endfunction

  task automatic note_load(input int a, input logic [DW-1:0] d);
    if (!pend_open) begin
      pend_open = 1'b1;
      pend_page = page_of(a);
    end
    pend_vld[a % NB] = 1'b1;
    pend_dat[a % NB] = d;
  endtask

  task automatic apply_pend();
    for (int i = 0; i < NB; i++) begin
      if (pend_vld[i]) mdl[pend_page*NB + i] = pend_dat[i];
      pend_vld[i] = 1'b0;
    end
    pend_open = 1'b0;
  endtask

  task automatic bus_idle();
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  // one write strobe; called and returns on a falling edge
  task automatic wr(input int a, input logic [DW-1:0] d, input bit abort);
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(a); din = d;
    @(negedge clk);
    if (abort) oe_n = 1'b0;
    @(negedge clk);
    if (abort) bus_idle(); else we_n = 1'b1;
    @(negedge clk);
    bus_idle();
  endtask

  task automatic acc_write(input int a, input logic [DW-1:0] d);
    wr(a, d, 1'b0);
    note_load(a, d);
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(a);
    @(negedge clk);
    v = rd_data;
    bus_idle();
  endtask

  task automatic wait_prog(input string tag);
    int w = 0;
    while (!busy && w < T + 10) begin @(negedge clk); w++; end
    chk(busy == 1'b1, tag, busy, 1);
    w = 0;
    while (busy && w < P + 10) begin @(negedge clk); w++; end
    chk(busy == 1'b0, "R6 busy falls", busy, 0);
    apply_pend();
  endtask

  task automatic check_addr(input int a, input string tag);
    logic [DW-1:0] v;
    rd(a, v);
    chk(v === exp_byte(a), tag, v, exp_byte(a));
  endtask

  task automatic check_page(input int pg, input string tag);
    for (int i = 0; i < NB; i++) check_addr(pg*NB + i, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    bit seen;
    void'($urandom(32'h00c0ffee));
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    for (int i = 0; i < NB; i++) pend_vld[i] = 1'b0;
    pend_open = 1'b0;
    pend_page = 0;
    rst_n = 1'b0; bus_idle(); addr = '0; din = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(rd_data == 8'h00, "R1 rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_addr(5, "R1 array clear");

    // R5/R6 exact timing, R9 read during busy, R7 write during busy
    acc_write(12'h045, 8'hA5);
    repeat (T - 1) @(negedge clk);
    chk(busy == 1'b0, "R5 busy before timeout", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R5 busy at timeout", busy, 1);
    rd(12'h045, v);
    chk(v == 8'h00, "R9 old data while busy", v, 0);
    wr(12'h046, 8'h77, 1'b0);
    repeat (P - 5) @(negedge clk);
    chk(busy == 1'b1, "R6 busy last cycle", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R6 busy end", busy, 0);
    apply_pend();
    check_addr(12'h045, "R6 committed");
    check_addr(12'h046, "R7 ignored while busy");

    // R5 boundary: join at the timeout edge, miss one edge later
    acc_write(12'h080, 8'h11);
    repeat (T - 1) @(negedge clk);
    chk(busy == 1'b0, "R5 still open", busy, 0);
    acc_write(12'h081, 8'h22);
    wait_prog("R5 busy after join");
    check_addr(12'h080, "R5 first byte");
    check_addr(12'h081, "R5 joined byte");
    acc_write(12'h0C0, 8'h33);
    repeat (T) @(negedge clk);
    chk(busy == 1'b1, "R5 late strobe sees busy", busy, 1);
    wr(12'h0C1, 8'h44, 1'b0);
    wait_prog("R5 busy late");
    check_addr(12'h0C0, "R5 page stored");
    check_addr(12'h0C1, "R7 late strobe dropped");

    // R2 address at strobe start, data at end; write-strobe then chip-select timing
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = 10'h100; din = 8'h5A;
    @(negedge clk);
    addr = 10'h1FF; din = 8'hC3;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    bus_idle();
    note_load(12'h100, 8'hC3);
    cs_n = 1'b1; we_n = 1'b0; addr = 10'h101; din = 8'h12;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    bus_idle();
    note_load(12'h101, 8'h12);
    wait_prog("R2 busy");
    check_addr(12'h100, "R2 data from last cycle");
    check_addr(12'h1FF, "R2 address from first cycle");
    check_addr(12'h101, "R2 chip-select timed write");

    // R3 inhibited strobes
    cs_n = 1'b1; we_n = 1'b0; oe_n = 1'b1; addr = 10'h200; din = 8'h99;
    repeat (3) @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_idle();
    @(negedge clk);
    wr(12'h201, 8'h66, 1'b1);
    seen = 1'b0;
    for (int i = 0; i < T + P + 5; i++) begin
      @(negedge clk);
      if (busy) seen = 1'b1;
    end
    chk(seen == 1'b0, "R3 no programming", seen, 0);
    check_addr(12'h200, "R3 inhibited write");
    check_addr(12'h201, "R3 aborted write");

    // R4 page lock, R8 overwrite and untouched positions
    acc_write(12'h240, 8'h01);
    wr(12'h2C0, 8'h02, 1'b0);
    acc_write(12'h240, 8'h03);
    acc_write(12'h27F, 8'h04);
    wait_prog("R4 busy");
    check_addr(12'h2C0, "R4 other page ignored");
    check_addr(12'h240, "R8 last byte wins");
    acc_write(12'h241, 8'h05);
    wait_prog("R8 busy");
    check_page(9, "R8 page contents");

    // random pages
    for (int it = 0; it < 10; it++) begin
      int pg, n, other, off;
      pg = $urandom_range(0, NPG - 1);
      n = $urandom_range(1, 10);
      off = $urandom_range(0, NB - 1);
      acc_write(pg*NB + off, DW'($urandom));
      for (int k = 0; k < n; k++) begin
        repeat ($urandom_range(0, 3)) @(negedge clk);
        if ($urandom_range(0, 3) == 0) begin
          other = (pg + 1 + $urandom_range(0, NPG - 2)) % NPG;
          wr(other*NB + $urandom_range(0, NB - 1), DW'($urandom), 1'b0);
          repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        off = $urandom_range(0, NB - 1);
        if ($urandom_range(0, 5) == 0) wr(pg*NB + off, DW'($urandom), 1'b1);
        else acc_write(pg*NB + off, DW'($urandom));
      end
      wait_prog("R5 random busy");
      check_page(pg, "R4 R8 random page");
      check_addr($urandom_range(0, DEPTH - 1), "R9 random read");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule